// File: doc/BRIEF.md
# Indexed Unsigned Dot-Product Accumulator

This block is a vector datapath that multiplies narrow unsigned lanes and accumulates them. Each destination element takes four consecutive narrow lanes of the first source vector and multiplies them lane by lane with four narrow lanes of the second source vector. It adds the four products to the matching element of the accumulator vector and returns the whole updated vector.

The second operand does not come from the matching element. A small immediate index picks one four-lane group inside every 128-bit segment of the second source. Every destination element in that segment uses the same group.

A size-mode bit sets the geometry. With 32-bit elements the lanes are 8 bits wide. With 64-bit elements the lanes are 16 bits wide. The vector length is a parameter and must be a multiple of 128 bits. A transaction enters with `in_valid_i` and leaves two cycles later with `out_valid_o`. The block has no backpressure.

Top module: `udp_dot_acc`

## Requirements
- R1: With `mode_i`=0, element e (bits 32e+31:32e) of `res_o` equals the same element of `acc_i` plus the sum over i=0..3 of first-source byte 4e+i times the selected second-source byte. The sum wraps modulo 2^32.
- R2: With `mode_i`=1, element e (bits 64e+63:64e) equals the same element of `acc_i` plus the sum over i=0..3 of first-source halfword 4e+i times the selected second-source halfword. The sum wraps modulo 2^64.
- R3: With `mode_i`=0, every element in 128-bit segment k uses second-source bytes 16k+4·`idx_i`+i, for `idx_i` values 0 to 3.
- R4: With `mode_i`=1, every element in 128-bit segment k uses second-source halfwords 8k+4·`idx_i[0]`+i. `idx_i[1]` has no effect on the result.
- R5: All lanes are unsigned. Products are zero-extended to the element width before they are added. All-ones operands wrap without saturating.
- R6: `out_valid_o` is high exactly two clock cycles after each cycle in which `in_valid_i` is high, and at no other time.
- R7: A new transaction can be accepted every cycle. Mode and index are captured with the operands, so back-to-back transactions in different modes each produce their own correct result.
- R8: `res_o` keeps its value in cycles where no transaction completes.
- R9: While reset is held and right after it is released, `out_valid_o` is 0 and `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Transaction strobe |
| mode_i | input | 1 | 0: 32-bit elements of 8-bit lanes; 1: 64-bit elements of 16-bit lanes |
| idx_i | input | 2 | Group index inside each 128-bit segment of the second source |
| src_a_i | input | VL | First source vector |
| src_b_i | input | VL | Second source vector (indexed) |
| acc_i | input | VL | Accumulator vector |
| out_valid_o | output | 1 | Result strobe, two cycles after the input strobe |
| res_o | output | VL | Accumulated result vector |

## Verification
The assertions assume that `in_valid_i` and `mode_i` are always at known levels after reset, and that the operands are known whenever the strobe is high. The stage-hold properties also assume the bench never raises the strobe during reset. The bench drives every input at the falling edge. It holds the strobe low through reset and raises it only after reset is released, with fully defined operands. Between transactions it parks the strobe low, so every captured transaction has defined mode, index and data.

// File: rtl/udp_pkg.sv
package udp_pkg;
  localparam int unsigned SEG_W = 128;
  localparam int unsigned GRP_N = 4;

  typedef enum logic {
    MODE_W32 = 1'b0,
    MODE_W64 = 1'b1
  } mode_e;
endpackage

// File: rtl/udp_grp_sel.sv
module udp_grp_sel
  import udp_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic [VL-1:0]        src_b_i,
  input  logic [1:0]           idx_i,
  output logic [NSEG*32-1:0]   grp8_o,
  output logic [NSEG*64-1:0]   grp16_o
);
  localparam int unsigned NSEG = VL / SEG_W;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [SEG_W-1:0] seg;
    assign seg = src_b_i[k*SEG_W +: SEG_W];

    // same group position repeats in every segment
    always_comb begin
      unique case (idx_i)
        2'd0:    grp8_o[k*32 +: 32] = seg[31:0];
        2'd1:    grp8_o[k*32 +: 32] = seg[63:32];
        2'd2:    grp8_o[k*32 +: 32] = seg[95:64];
        default: grp8_o[k*32 +: 32] = seg[127:96];
      endcase
    end

    // wide lanes: only idx bit 0 is meaningful
    assign grp16_o[k*64 +: 64] = idx_i[0] ? seg[127:64] : seg[63:0];
  end
endmodule

// File: rtl/udp_mul_stage.sv
module udp_mul_stage
  import udp_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  mode_e                mode_i,
  input  logic [VL-1:0]        src_a_i,
  input  logic [VL-1:0]        acc_i,
  input  logic [NSEG*32-1:0]   grp8_i,
  input  logic [NSEG*64-1:0]   grp16_i,
  output logic                 valid_o,
  output mode_e                mode_o,
  output logic [VL-1:0]        acc_o,
  output logic [P_W-1:0]       p8_o,
  output logic [P_W-1:0]       p16_o
);
  localparam int unsigned NSEG = VL / SEG_W;
  localparam int unsigned N32  = VL / 32;
  localparam int unsigned N64  = VL / 64;
  localparam int unsigned P_W  = VL * 2;

  logic [P_W-1:0] p8_d, p16_d;

  for (genvar e = 0; e < N32; e++) begin : g_e32
    localparam int unsigned SEG = e / 4;
    for (genvar i = 0; i < GRP_N; i++) begin : g_ln
      logic [7:0] la, lb;
      assign la = src_a_i[(4*e+i)*8 +: 8];
      assign lb = grp8_i[SEG*32 + i*8 +: 8];
      assign p8_d[(4*e+i)*16 +: 16] = la * lb;
    end
  end

  for (genvar e = 0; e < N64; e++) begin : g_e64
    localparam int unsigned SEG = e / 2;
    for (genvar i = 0; i < GRP_N; i++) begin : g_ln
      logic [15:0] la, lb;
      assign la = src_a_i[(4*e+i)*16 +: 16];
      assign lb = grp16_i[SEG*64 + i*16 +: 16];
      assign p16_d[(4*e+i)*32 +: 32] = la * lb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_W32;
      acc_o  <= '0;
      p8_o   <= '0;
      p16_o  <= '0;
    end else if (valid_i) begin
      mode_o <= mode_i;
      acc_o  <= acc_i;
      p8_o   <= p8_d;
      p16_o  <= p16_d;
    end
  end

  AST_S1_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_S1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6
  AST_S1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(p8_o) && $stable(p16_o) && $stable(acc_o))); // R8
endmodule

// File: rtl/udp_sum_stage.sv
module udp_sum_stage
  import udp_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  mode_e             mode_i,
  input  logic [VL-1:0]     acc_i,
  input  logic [P_W-1:0]    p8_i,
  input  logic [P_W-1:0]    p16_i,
  output logic              valid_o,
  output logic [VL-1:0]     res_o
);
  localparam int unsigned N32 = VL / 32;
  localparam int unsigned N64 = VL / 64;
  localparam int unsigned P_W = VL * 2;

  logic [VL-1:0] r32, r64;

  for (genvar e = 0; e < N32; e++) begin : g_e32
    always_comb begin
      r32[e*32 +: 32] = acc_i[e*32 +: 32];
      for (int i = 0; i < GRP_N; i++)
        r32[e*32 +: 32] = r32[e*32 +: 32] + {16'h0, p8_i[(4*e+i)*16 +: 16]};
    end
  end

  for (genvar e = 0; e < N64; e++) begin : g_e64
    always_comb begin
      r64[e*64 +: 64] = acc_i[e*64 +: 64];
      for (int i = 0; i < GRP_N; i++)
        r64[e*64 +: 64] = r64[e*64 +: 64] + {32'h0, p16_i[(4*e+i)*32 +: 32]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_o <= '0;
    else if (valid_i) res_o <= (mode_i == MODE_W64) ? r64 : r32;
  end

  AST_OUT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o)); // R8
endmodule

// File: rtl/udp_dot_acc.sv
module udp_dot_acc
  import udp_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          mode_i,
  input  logic [1:0]    idx_i,
  input  logic [VL-1:0] src_a_i,
  input  logic [VL-1:0] src_b_i,
  input  logic [VL-1:0] acc_i,
  output logic          out_valid_o,
  output logic [VL-1:0] res_o
);
  localparam int unsigned NSEG = VL / SEG_W;
  localparam int unsigned P_W  = VL * 2;

  logic [NSEG*32-1:0] grp8;
  logic [NSEG*64-1:0] grp16;
  logic               s1_valid;
  mode_e              s1_mode;
  mode_e              in_mode;
  logic [VL-1:0]      s1_acc;
  logic [P_W-1:0]     s1_p8, s1_p16;

  assign in_mode = mode_e'(mode_i);

  udp_grp_sel #(.VL(VL)) u_grp_sel (
    .src_b_i (src_b_i),
    .idx_i   (idx_i),
    .grp8_o  (grp8),
    .grp16_o (grp16)
  );

  udp_mul_stage #(.VL(VL)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .mode_i  (in_mode),
    .src_a_i (src_a_i),
    .acc_i   (acc_i),
    .grp8_i  (grp8),
    .grp16_i (grp16),
    .valid_o (s1_valid),
    .mode_o  (s1_mode),
    .acc_o   (s1_acc),
    .p8_o    (s1_p8),
    .p16_o   (s1_p16)
  );

  udp_sum_stage #(.VL(VL)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .mode_i  (s1_mode),
    .acc_i   (s1_acc),
    .p8_i    (s1_p8),
    .p16_i   (s1_p16),
    .valid_o (out_valid_o),
    .res_o   (res_o)
  );

  AST_RES_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$isunknown(res_o)); // R1
endmodule

// File: tb/tb_udp_dot_acc.sv
module tb_udp_dot_acc;
  localparam int unsigned VL = 256;

  typedef struct {
    logic [VL-1:0] res;
    int            due;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          mode = 1'b0;
  logic [1:0]    idx = '0;
  logic [VL-1:0] a = '0, b = '0, c = '0;
  logic          out_valid;
  logic [VL-1:0] res;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  udp_dot_acc #(.VL(VL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .mode_i(mode),
    .idx_i(idx), .src_a_i(a), .src_b_i(b), .acc_i(c),
    .out_valid_o(out_valid), .res_o(res)
  );

  function automatic logic [VL-1:0] model(logic [VL-1:0] sa, logic [VL-1:0] sb,
                                          logic [VL-1:0] sc, logic m, logic [1:0] ix);
    logic [VL-1:0] r;
    r = '0;
    if (!m) begin
      for (int e = 0; e < VL/32; e++) begin
        int s;
        logic [31:0] acc;
        s = (e / 4) * 4 + int'(ix);
        acc = sc[e*32 +: 32];
        for (int i = 0; i < 4; i++)
          acc = acc + 32'(sa[(4*e+i)*8 +: 8]) * 32'(sb[(4*s+i)*8 +: 8]);
        r[e*32 +: 32] = acc;
      end
    end else begin
      for (int e = 0; e < VL/64; e++) begin
        int s;
        logic [63:0] acc;
        s = (e / 2) * 2 + int'(ix[0]);
        acc = sc[e*64 +: 64];
        for (int i = 0; i < 4; i++)
          acc = acc + 64'(sa[(4*e+i)*16 +: 16]) * 64'(sb[(4*s+i)*16 +: 16]);
        r[e*64 +: 64] = acc;
      end
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [VL-1:0] sa, logic [VL-1:0] sb, logic [VL-1:0] sc,
                       logic m, logic [1:0] ix, string tag);
    exp_t it;
    @(negedge clk);
    a = sa; b = sb; c = sc; mode = m; idx = ix; in_valid = 1'b1;
    it.res = model(sa, sb, sc, m, ix);
    it.due = cyc + 2;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R6 unexpected out_valid", res, '0);
      end else begin
        exp_t it;
        it = q.pop_front();
        check(res === it.res, it.tag, res, it.res);
        check(cyc == it.due, "R6 latency", VL'(cyc), VL'(it.due));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VL-1:0] ones, snap, ta, tb_v, tc;
    ones = '1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && res === '0, "R9 reset state", res, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && res === '0, "R9 after release", res, '0);

    // R1 R3: every index, 32-bit elements
    for (int k = 0; k < 4; k++)
      drive(rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 2'(k), "R1 R3 w32 index");
    idle(3);
    // R2: both indices, 64-bit elements
    for (int k = 0; k < 2; k++)
      drive(rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 2'(k), "R2 w64 index");
    idle(3);
    // R4: idx bit 1 ignored in 64-bit mode
    ta = rnd_vec(); tb_v = rnd_vec(); tc = rnd_vec();
    drive(ta, tb_v, tc, 1'b1, 2'd2, "R4 idx=2 acts as 0");
    drive(ta, tb_v, tc, 1'b1, 2'd3, "R4 idx=3 acts as 1");
    idle(3);
    // R5: all-ones wraparound
    for (int k = 0; k < 4; k++)
      drive(ones, ones, ones, 1'b0, 2'(k), "R5 w32 all ones");
    drive(ones, ones, ones, 1'b1, 2'd0, "R5 w64 all ones");
    drive(ones, ones, '0, 1'b1, 2'd1, "R5 w64 ones zero acc");
    idle(3);
    // R7: back-to-back alternating modes
    for (int k = 0; k < 10; k++)
      drive(rnd_vec(), rnd_vec(), rnd_vec(), 1'(k % 2), 2'($urandom % 4), "R7 back-to-back");
    idle(4);
    // R8: output holds while idle
    snap = res;
    a = rnd_vec(); b = rnd_vec(); c = rnd_vec(); mode = 1'b1;
    idle(6);
    check(res === snap && out_valid === 1'b0, "R8 hold while idle", res, snap);
    check(q.size() == 0, "R6 all results delivered", VL'(q.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule